// File: doc/BRIEF.md
# Programmable-Accuracy Single-Precision Multiplier

This block multiplies two binary32 operands. Each operation carries an accuracy count that gives the number of leading significand bits the caller needs. Inside the 24×24 significand multiply, any partial-product bit whose column is too low to reach those leading bits is forced to zero before the columns are summed. This cuts adder switching on low-accuracy work. The sign and exponent are always exact, so every error stays in the mantissa.

The datapath has two register stages. The first stage classifies the operands, forms the exact sign and biased exponent sum, and sums the masked partial-product matrix. The second stage normalises the product, truncates it to the requested width, handles special values, overflow and underflow, and registers the result. Subnormal inputs count as zero. No rounding is done: results are truncated.

Top module: `anyfp_mul`

## Requirements
- R1: `out_valid` is high in exactly the cycle two rising edges after `in_valid` was sampled high. Back-to-back operations come out on back-to-back cycles, and `out_valid` is low otherwise.
- R2: An accuracy of 0 or of 25 to 31 selects full accuracy. No partial-product bit is masked and no fraction bit is forced. The result is the exact 48-bit significand product, truncated.
- R3: For an accuracy `a` from 1 to 24, every partial-product bit of column weight below 45−a is zeroed before summation. Column 46 of the 48-bit product has weight 1.0, which leaves two guard columns under the requested bits.
- R4: If the masked product is 2.0 or more (bit 47 set), it is shifted right by one and the exponent is raised by one. Otherwise bits 45..23 form the fraction.
- R5: For an accuracy `a` from 1 to 24, only the top a−1 fraction bits (bits 22 down to 24−a) may be nonzero. Bits 23−a down to 0 of the result are forced to zero.
- R6: The result sign is the XOR of the operand signs. The result exponent is ea+eb−127 plus the normalisation increment.
- R7: An operand with exponent field 0 (zero or subnormal), multiplied by a finite operand, gives a zero carrying the XOR sign.
- R8: Any NaN operand, or an infinity times a zero, gives the quiet NaN 0x7FC00000.
- R9: An infinity times a nonzero non-NaN operand gives an infinity with the XOR sign.
- R10: A final exponent of 255 or more gives a signed infinity. A final exponent of 0 or less gives a signed zero.
- R11: During and just after reset, `out_valid` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_a | input | 32 | Multiplicand, binary32 |
| in_b | input | 32 | Multiplier, binary32 |
| in_acc | input | 5 | Requested leading significand bits (0 or >24 = full) |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_result | output | 32 | Product, binary32 |

## Verification
A bad column cut or a bad mask decode changes the low fraction bits of the very result that used it, two cycles after issue. A sweep over every accuracy code with many operand patterns, compared against an arithmetic model, catches it on the first operand whose bits land near the cut. A bad operand class, sign or exponent path shows up at once as a wrong special value or exponent field on the next output. A broken valid pipeline shows up as a missing, early or repeated strobe within the same three-cycle window.

// File: rtl/anyfp_pkg.sv
package anyfp_pkg;
    typedef enum logic [1:0] {
        K_NUM  = 2'd0,
        K_ZERO = 2'd1,
        K_INF  = 2'd2,
        K_NAN  = 2'd3
    } opkind_t;
endpackage

// File: rtl/anyfp_classify.sv
module anyfp_classify
    import anyfp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output opkind_t               kind
);
    localparam logic [EXP_W-1:0] EXP_ONES = '1;

    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    assign ex = op[EXP_W+FRAC_W-1 -: EXP_W];
    assign fr = op[FRAC_W-1:0];

    always_comb begin
        if (ex == EXP_ONES)
            kind = (fr != '0) ? K_NAN : K_INF;
        else if (ex == '0)
            kind = K_ZERO;
        else
            kind = K_NUM;
    end
endmodule

// File: rtl/anyfp_mask_array.sv
module anyfp_mask_array #(
    parameter int SIG_W = 24,
    parameter int CUT_W = 6
) (
    input  logic [SIG_W-1:0]   ma,
    input  logic [SIG_W-1:0]   mb,
    input  logic [CUT_W-1:0]   cut,
    output logic [2*SIG_W-1:0] prod
);
    localparam int PW = 2 * SIG_W;

    logic [PW-1:0] colmask;
    logic [PW-1:0] rows [SIG_W];

    assign colmask = {PW{1'b1}} << cut;

    for (genvar j = 0; j < SIG_W; j++) begin : g_row
        assign rows[j] = ({{SIG_W{1'b0}}, ma} << j) & colmask & {PW{mb[j]}};
    end

    always_comb begin
        prod = '0;
        for (int j = 0; j < SIG_W; j++)
            prod = prod + rows[j];
    end
endmodule

// File: rtl/anyfp_normalize.sv
module anyfp_normalize #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [2*FRAC_W+1:0]      prod,
    input  logic signed [EXP_W+1:0]  exp_in,
    input  logic [FRAC_W-1:0]        drop,
    output logic [FRAC_W-1:0]        frac,
    output logic signed [EXP_W+1:0]  exp_out
);
    localparam int PW = 2 * FRAC_W + 2;

    logic              norm;
    logic [FRAC_W-1:0] frac_raw;

    assign norm     = prod[PW-1];
    assign frac_raw = norm ? prod[PW-2 -: FRAC_W] : prod[PW-3 -: FRAC_W];
    assign frac     = frac_raw & ~drop;
    assign exp_out  = exp_in + {{(EXP_W+1){1'b0}}, norm};
endmodule

// File: rtl/anyfp_mul.sv
module anyfp_mul
    import anyfp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int ACC_W  = 5,
    parameter int GUARD  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [EXP_W+FRAC_W:0]  in_a,
    input  logic [EXP_W+FRAC_W:0]  in_b,
    input  logic [ACC_W-1:0]       in_acc,
    output logic                   out_valid,
    output logic [EXP_W+FRAC_W:0]  out_result
);
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PW      = 2 * SIG_W;
    localparam int WORD_W  = EXP_W + FRAC_W + 1;
    localparam int CUT_W   = $clog2(PW) + 1;
    localparam int SE_W    = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam logic [WORD_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // ---------------- stage 1: classify, exponent, masked matrix
    opkind_t           kind_a, kind_b, kind_c;
    logic              acc_on;
    logic [CUT_W-1:0]  cut;
    logic [FRAC_W-1:0] drop;
    logic [PW-1:0]     prod_c;
    logic signed [SE_W-1:0] exp_c;

    anyfp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (.op(in_a), .kind(kind_a));
    anyfp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (.op(in_b), .kind(kind_b));

    assign acc_on = (in_acc != '0) && (int'(in_acc) <= SIG_W);
    assign cut    = acc_on ? CUT_W'(PW - 1 - GUARD - int'(in_acc)) : '0;
    assign drop   = acc_on ? ({FRAC_W{1'b1}} >> (in_acc - 1'b1)) : '0;
    assign exp_c  = $signed({2'b00, in_a[WORD_W-2 -: EXP_W]})
                  + $signed({2'b00, in_b[WORD_W-2 -: EXP_W]})
                  - SE_W'(BIAS);

    always_comb begin
        if (kind_a == K_NAN || kind_b == K_NAN)
            kind_c = K_NAN;
        else if ((kind_a == K_INF && kind_b == K_ZERO) ||
                 (kind_a == K_ZERO && kind_b == K_INF))
            kind_c = K_NAN;
        else if (kind_a == K_INF || kind_b == K_INF)
            kind_c = K_INF;
        else if (kind_a == K_ZERO || kind_b == K_ZERO)
            kind_c = K_ZERO;
        else
            kind_c = K_NUM;
    end

    anyfp_mask_array #(.SIG_W(SIG_W), .CUT_W(CUT_W)) u_array (
        .ma  ({1'b1, in_a[FRAC_W-1:0]}),
        .mb  ({1'b1, in_b[FRAC_W-1:0]}),
        .cut (cut),
        .prod(prod_c)
    );

    logic                   s1_valid, s1_sign;
    opkind_t                s1_kind;
    logic signed [SE_W-1:0] s1_exp;
    logic [PW-1:0]          s1_prod;
    logic [FRAC_W-1:0]      s1_drop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sign  <= 1'b0;
            s1_kind  <= K_ZERO;
            s1_exp   <= '0;
            s1_prod  <= '0;
            s1_drop  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_sign  <= in_a[WORD_W-1] ^ in_b[WORD_W-1];
            s1_kind  <= kind_c;
            s1_exp   <= exp_c;
            s1_prod  <= prod_c;
            s1_drop  <= drop;
        end
    end

    // ---------------- stage 2: normalise, truncate, assemble
    logic [FRAC_W-1:0]      frac_n;
    logic signed [SE_W-1:0] exp_n;
    logic [WORD_W-1:0]      word_c;

    anyfp_normalize #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
        .prod   (s1_prod),
        .exp_in (s1_exp),
        .drop   (s1_drop),
        .frac   (frac_n),
        .exp_out(exp_n)
    );

    always_comb begin
        unique case (s1_kind)
            K_NAN:  word_c = QNAN;
            K_INF:  word_c = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            K_ZERO: word_c = {s1_sign, {(WORD_W-1){1'b0}}};
            K_NUM: begin
                if (exp_n >= SE_W'(EXP_MAX))
                    word_c = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                else if (exp_n <= 0)
                    word_c = {s1_sign, {(WORD_W-1){1'b0}}};
                else
                    word_c = {s1_sign, exp_n[EXP_W-1:0], frac_n};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= s1_valid;
            out_result <= word_c;
        end
    end

    // ---------------- assertions
    // R1
    s1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    // R1
    out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    // R1
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);
    // R3
    lead_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_kind == K_NUM) |-> (s1_prod[PW-1] | s1_prod[PW-2]));
    // R6
    sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_kind != K_NAN) |=> (out_result[WORD_W-1] == $past(s1_sign)));
    // R5
    trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_kind == K_NUM) |=> ((out_result[FRAC_W-1:0] & $past(s1_drop)) == '0));
    // R8
    qnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result[WORD_W-2 -: EXP_W] == '1 && out_result[FRAC_W-1:0] != '0)
        |-> out_result[FRAC_W-1]);
endmodule

// File: tb/sim_anyfp_mul.sv
module sim_anyfp_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0, in_b = '0;
    logic [4:0]  in_acc = '0;
    logic        out_valid;
    logic [31:0] out_result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    anyfp_mul u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, int acc);
        int  ea = int'(a[30:23]);
        int  eb = int'(b[30:23]);
        bit  sg = a[31] ^ b[31];
        bit  nan_a = (ea == 255) && (a[22:0] != 0);
        bit  nan_b = (eb == 255) && (b[22:0] != 0);
        bit  inf_a = (ea == 255) && (a[22:0] == 0);
        bit  inf_b = (eb == 255) && (b[22:0] == 0);
        bit  zr_a = (ea == 0);
        bit  zr_b = (eb == 0);
        int  cut, e;
        logic [23:0] ma, mb;
        logic [47:0] p;
        logic [22:0] fr, dm;
        if (nan_a || nan_b || (inf_a && zr_b) || (zr_a && inf_b)) return 32'h7FC0_0000;
        if (inf_a || inf_b) return {sg, 8'hFF, 23'h0};
        if (zr_a || zr_b)   return {sg, 31'h0};
        ma = {1'b1, a[22:0]};
        mb = {1'b1, b[22:0]};
        cut = (acc >= 1 && acc <= 24) ? 45 - acc : 0;
        p = '0;
        for (int i = 0; i < 24; i++)
            for (int j = 0; j < 24; j++)
                if (ma[i] && mb[j] && (i + j) >= cut) p = p + (48'd1 << (i + j));
        e = ea + eb - 127;
        if (p[47]) begin fr = p[46:24]; e = e + 1; end
        else fr = p[45:23];
        dm = (acc >= 1 && acc <= 24) ? 23'((24'd1 << (24 - acc)) - 1) : 23'd0;
        fr = fr & ~dm;
        if (e >= 255) return {sg, 8'hFF, 23'h0};
        if (e <= 0)   return {sg, 31'h0};
        return {sg, 8'(e), fr};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [31:0] a, logic [31:0] b, int acc, logic [31:0] exp, string tag);
        @(negedge clk);
        in_a = a; in_b = b; in_acc = 5'(acc); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid && out_result == exp, tag, out_result, exp);
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    initial begin : watchdog
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] x, y, e1, e2;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(out_valid == 1'b0 && out_result == 32'h0, "R11 reset", out_result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 idle after reset", {31'h0, out_valid}, 32'h0);

        // R4 normalisation with and without truncation (1.5*1.5)
        run_op(32'h3FC0_0000, 32'h3FC0_0000, 0, 32'h4010_0000, "R4 full");
        run_op(32'h3FC0_0000, 32'h3FC0_0000, 2, 32'h4000_0000, "R4 R5 acc2");
        // R6 sign and exponent
        run_op(32'h4000_0000, 32'h4040_0000, 0, 32'h40C0_0000, "R6 2*3");
        run_op(32'hC000_0000, 32'h4040_0000, 31, 32'hC0C0_0000, "R6 -2*3");
        // R7 zero and subnormal
        run_op(32'h0000_0000, 32'hBF80_0000, 5, 32'h8000_0000, "R7 zero");
        run_op(32'h0000_0001, 32'h3F80_0000, 0, 32'h0000_0000, "R7 subnormal");
        // R8 NaN cases
        run_op(32'h7F80_0001, 32'h3F80_0000, 0, 32'h7FC0_0000, "R8 nan");
        run_op(32'h7F80_0000, 32'h8000_0000, 0, 32'h7FC0_0000, "R8 inf*0");
        // R9 infinity
        run_op(32'hFF80_0000, 32'h4000_0000, 7, 32'hFF80_0000, "R9 inf");
        // R10 overflow and underflow
        run_op(32'h7F00_0000, 32'h7F00_0000, 0, 32'h7F80_0000, "R10 overflow");
        run_op(32'h8080_0000, 32'h0080_0000, 0, 32'h8000_0000, "R10 underflow");
        // R3 masking on all-ones significands at the two extremes
        run_op(32'h3FFF_FFFF, 32'h3FFF_FFFF, 1, model(32'h3FFF_FFFF, 32'h3FFF_FFFF, 1), "R3 acc1");
        run_op(32'h3FFF_FFFF, 32'h3FFF_FFFF, 24, model(32'h3FFF_FFFF, 32'h3FFF_FFFF, 24), "R3 acc24");

        // R1 back-to-back issue, then idle
        e1 = model(32'h3FC0_0000, 32'h4000_0000, 0);
        e2 = model(32'h4040_0000, 32'h4040_0000, 0);
        @(negedge clk);
        in_a = 32'h3FC0_0000; in_b = 32'h4000_0000; in_acc = 0; in_valid = 1'b1;
        @(negedge clk);
        in_a = 32'h4040_0000; in_b = 32'h4040_0000;
        chk(out_valid == 1'b0, "R1 no early valid", {31'h0, out_valid}, 32'h0);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && out_result == e1, "R1 first", out_result, e1);
        @(negedge clk);
        chk(out_valid && out_result == e2, "R1 second", out_result, e2);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle", {31'h0, out_valid}, 32'h0);

        // Sweep every accuracy code over many operand patterns
        for (int acc = 0; acc < 32; acc++) begin
            for (int k = 0; k < 40; k++) begin
                x = rnd(); y = rnd();
                if (k < 30) begin
                    x[30:23] = 8'(110 + (rnd() % 36));
                    y[30:23] = 8'(110 + (rnd() % 36));
                end
                if (k % 7 == 0) x[22:0] = '1;
                if (k % 11 == 0) y[22:0] = '1;
                run_op(x, y, acc, model(x, y, acc),
                       (acc >= 1 && acc <= 24) ? "R3 R5 R4 R6 sweep" : "R2 R4 R6 sweep");
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule